// File: doc/BRIEF.md
# Two-Rank Routing Control for an 8x4 Crosspoint

This block holds the routing state of a matrix that connects any of eight sources to each of four outputs. A host drives it through a parallel strobe port: a 2-bit output address plus a 4-bit data word are staged into one of four first-rank entries. A separate commit strobe copies all four staged entries into a second rank at once. The second rank drives a 3-bit source select and an enable for each output, so a complete new routing can be prepared without disturbing live traffic and then switched in one step.

The top bit of the data word turns the addressed output off instead of naming a source. Reset leaves every output off. A sleep input forces every enable low while keeping the stored routing, so the routing can be loaded during sleep and appears when sleep ends. All strobes are active low and asynchronous to the block clock. They pass through a synchronizer, and the address and data follow a pipeline of the same depth. A "transparent" latch is modelled as a register that loads on every clock in which its strobe condition holds.

Top module: `xpt_ctrl`

## Requirements
- R1: After reset every enable bit is 0, every select code reads 0 and the sleep indication is 0.
- R2: A write staged while the commit strobe is high leaves all select and enable outputs unchanged.
- R3: While the commit strobe is low, all four outputs take the contents of their staged entries together.
- R4: Address value k (00 to 11) stages data only for output k. The other three staged entries keep their values.
- R5: A data word with bit 3 at 0 routes the addressed output to the source whose number is in bits 2:0, and the output's enable reads 1.
- R6: A data word with bit 3 at 1 turns the addressed output off: its enable reads 0 and its select code reads 0, whatever bits 2:0 hold.
- R7: Staging needs both chip-select and write strobes low at the same time. Either one low alone changes no entry.
- R8: With chip-select, write and commit all low, the addressed output shows the incoming data. The other outputs show the entries staged earlier.
- R9: While sleep is 1, every enable reads 0, the select codes and sleep indication still reflect stored state, and staging and commit still work. After sleep returns to 0, the stored routing is enabled again.
- R10: A write with the commit strobe low changes the outputs on the third rising clock edge that samples it, and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chip_sel_n_i | input | 1 | Chip-select strobe, active low |
| wr_n_i | input | 1 | Write strobe, active low |
| commit_n_i | input | 1 | Commit strobe to the second rank, active low |
| sleep_i | input | 1 | Sleep request, active high |
| addr_i | input | 2 | Output number that a write applies to |
| data_i | input | 4 | Bit 3 = off, bits 2:0 = source number |
| route_sel_o | output | 12 | Source select, 3 bits per output, output 0 in bits 2:0 |
| route_en_o | output | 4 | Enable per output, bit k for output k |
| asleep_o | output | 1 | Synchronized sleep indication |

## Verification
A corrupted first-rank entry stays invisible at the ports until the next commit. The bench therefore always follows a staged write with a commit and reads every output, including the outputs it did not address. A wrong second-rank entry shows up at once on the select or enable of its output. It is caught in the wait after each scenario, which is a few cycles longer than the three-edge path. The path length itself is checked by sampling one output both before and on the edge where it must change.

// File: rtl/xpt_pkg.sv
`timescale 1ns/1ps
package xpt_pkg;
    localparam int SYNC_DEPTH_DEF = 2;

    typedef struct packed {
        logic wr_go;
        logic upd_go;
        logic mute;
    } xpt_ctl_t;
endpackage

// File: rtl/xpt_sync.sv
`timescale 1ns/1ps
module xpt_sync #(
    parameter int W = 1,
    parameter int DEPTH = 2,
    parameter logic [W-1:0] RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] in_i,
    output logic [W-1:0] out_o
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] st;
    } sync_t;

    sync_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        nxt_d.st[0] = in_i;
        for (int k = 1; k < DEPTH; k++) begin
            nxt_d.st[k] = cur_q.st[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q.st <= {DEPTH{RST}};
        else        cur_q <= nxt_d;
    end

    assign out_o = cur_q.st[DEPTH-1];
endmodule

// File: rtl/xpt_stage_bank.sv
`timescale 1ns/1ps
module xpt_stage_bank #(
    parameter int N_CH = 4,
    parameter int ENT_W = 4,
    parameter int AW = 2,
    parameter logic [ENT_W-1:0] RST_ENT = '0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load_i,
    input  logic [AW-1:0]         addr_i,
    input  logic [ENT_W-1:0]      wdata_i,
    output logic [N_CH*ENT_W-1:0] ent_d_o,
    output logic [N_CH*ENT_W-1:0] ent_q_o
);
    typedef struct packed {
        logic [N_CH-1:0][ENT_W-1:0] ent;
    } bank_t;

    bank_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (load_i && (int'(addr_i) < N_CH)) begin
            nxt_d.ent[addr_i] = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q.ent <= {N_CH{RST_ENT}};
        else        cur_q <= nxt_d;
    end

    assign ent_d_o = nxt_d.ent;
    assign ent_q_o = cur_q.ent;
endmodule

// File: rtl/xpt_switch_bank.sv
`timescale 1ns/1ps
module xpt_switch_bank #(
    parameter int N_CH = 4,
    parameter int SRC_W = 3,
    parameter int ENT_W = SRC_W + 1,
    parameter logic [ENT_W-1:0] RST_ENT = '0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load_i,
    input  logic [N_CH*ENT_W-1:0] src_i,
    output logic [N_CH*ENT_W-1:0] sw_q_o,
    output logic [N_CH*SRC_W-1:0] sel_o,
    output logic [N_CH-1:0]       act_o
);
    typedef struct packed {
        logic [N_CH-1:0][ENT_W-1:0] ent;
    } bank_t;

    bank_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (load_i) nxt_d.ent = src_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q.ent <= {N_CH{RST_ENT}};
        else        cur_q <= nxt_d;
    end

    assign sw_q_o = cur_q.ent;

    for (genvar i = 0; i < N_CH; i++) begin : g_dec
        logic off;
        assign off = cur_q.ent[i][ENT_W-1];
        assign act_o[i] = ~off;
        assign sel_o[i*SRC_W +: SRC_W] = off ? '0 : cur_q.ent[i][SRC_W-1:0];
    end
endmodule

// File: rtl/xpt_ctrl.sv
`timescale 1ns/1ps
module xpt_ctrl #(
    parameter int N_IN = 8,
    parameter int N_OUT = 4,
    parameter int SYNC_DEPTH = xpt_pkg::SYNC_DEPTH_DEF
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            chip_sel_n_i,
    input  logic                            wr_n_i,
    input  logic                            commit_n_i,
    input  logic                            sleep_i,
    input  logic [$clog2(N_OUT)-1:0]        addr_i,
    input  logic [$clog2(N_IN):0]           data_i,
    output logic [N_OUT*$clog2(N_IN)-1:0]   route_sel_o,
    output logic [N_OUT-1:0]                route_en_o,
    output logic                            asleep_o
);
    import xpt_pkg::*;

    localparam int SRC_W = $clog2(N_IN);
    localparam int ENT_W = SRC_W + 1;
    localparam int AW    = $clog2(N_OUT);
    localparam logic [ENT_W-1:0] RST_ENT = {1'b1, {SRC_W{1'b0}}};
    localparam int PW    = AW + ENT_W;

    logic [3:0]           strobe_s;
    logic [PW-1:0]        payload_s;
    xpt_ctl_t             ctl;
    logic                 wr_go;
    logic                 upd_go;
    logic [N_OUT*ENT_W-1:0] stage_d;
    logic [N_OUT*ENT_W-1:0] stage_q;
    logic [N_OUT*ENT_W-1:0] sw_q;
    logic [N_OUT-1:0]       act;

    xpt_sync #(.W(4), .DEPTH(SYNC_DEPTH), .RST(4'b1110)) u_sync_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .in_i  ({chip_sel_n_i, wr_n_i, commit_n_i, sleep_i}),
        .out_o (strobe_s)
    );

    xpt_sync #(.W(PW), .DEPTH(SYNC_DEPTH), .RST('0)) u_sync_pay (
        .clk   (clk),
        .rst_n (rst_n),
        .in_i  ({addr_i, data_i}),
        .out_o (payload_s)
    );

    always_comb begin
        ctl.wr_go  = ~strobe_s[3] & ~strobe_s[2];
        ctl.upd_go = ~strobe_s[1];
        ctl.mute   = strobe_s[0];
    end

    assign wr_go  = ctl.wr_go;
    assign upd_go = ctl.upd_go;

    xpt_stage_bank #(.N_CH(N_OUT), .ENT_W(ENT_W), .AW(AW), .RST_ENT(RST_ENT)) u_stage (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (wr_go),
        .addr_i  (payload_s[PW-1 -: AW]),
        .wdata_i (payload_s[ENT_W-1:0]),
        .ent_d_o (stage_d),
        .ent_q_o (stage_q)
    );

    xpt_switch_bank #(.N_CH(N_OUT), .SRC_W(SRC_W), .ENT_W(ENT_W), .RST_ENT(RST_ENT)) u_switch (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (upd_go),
        .src_i  (stage_d),
        .sw_q_o (sw_q),
        .sel_o  (route_sel_o),
        .act_o  (act)
    );

    assign route_en_o = act & {N_OUT{~ctl.mute}};
    assign asleep_o   = ctl.mute;
endmodule

// File: rtl/xpt_ctrl_chk.sv
`timescale 1ns/1ps
module xpt_ctrl_chk #(
    parameter int N_CH = 4,
    parameter int ENT_W = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wr_go,
    input logic                  upd_go,
    input logic [N_CH*ENT_W-1:0] stage_q,
    input logic [N_CH*ENT_W-1:0] sw_q,
    input logic [N_CH-1:0]       route_en_o
);
    logic [N_CH*ENT_W-1:0] prev_q;
    logic [N_CH-1:0]       chg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= stage_q;
    end

    for (genvar i = 0; i < N_CH; i++) begin : g_chg
        assign chg[i] = |(stage_q[i*ENT_W +: ENT_W] ^ prev_q[i*ENT_W +: ENT_W]);
    end

    p_reset_off_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (route_en_o == '0));

    p_stage_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_go |=> $stable(sw_q));

    p_copy_all_r3: assert property (@(posedge clk) disable iff (!rst_n)
        upd_go |=> (sw_q == stage_q));

    p_one_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go |=> ($countones(chg) <= 1));

    p_stage_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_go |=> $stable(stage_q));
endmodule

bind xpt_ctrl xpt_ctrl_chk #(.N_CH(N_OUT), .ENT_W(ENT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_go      (wr_go),
    .upd_go     (upd_go),
    .stage_q    (stage_q),
    .sw_q       (sw_q),
    .route_en_o (route_en_o)
);

// File: tb/xpt_ctrl_bench.sv
`timescale 1ns/1ps
module xpt_ctrl_bench;
    localparam int NO = 4;
    localparam int SW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic csn = 1'b1, wrn = 1'b1, updn = 1'b1, sleep = 1'b0;
    logic [1:0] addr = '0;
    logic [3:0] data = '0;
    logic [NO*SW-1:0] sel;
    logic [NO-1:0] en;
    logic asleep;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic [3:0] stg [NO];
    logic [3:0] live [NO];
    bit sleeping = 0;

    always #10 clk = ~clk;

    xpt_ctrl u_xpt_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .chip_sel_n_i (csn),
        .wr_n_i       (wrn),
        .commit_n_i   (updn),
        .sleep_i      (sleep),
        .addr_i       (addr),
        .data_i       (data),
        .route_sel_o  (sel),
        .route_en_o   (en),
        .asleep_o     (asleep)
    );

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_all(string req);
        for (int i = 0; i < NO; i++) begin
            int es = live[i][3] ? 0 : int'(live[i][2:0]);
            int ee = (!live[i][3] && !sleeping) ? 1 : 0;
            chk($sformatf("%s out%0d sel", req, i), int'(sel[i*SW +: SW]), es);
            chk($sformatf("%s out%0d en", req, i), int'(en[i]), ee);
        end
        chk({req, " asleep"}, int'(asleep), int'(sleeping));
    endtask

    task automatic stage_write(logic [1:0] a, logic [3:0] d);
        @(negedge clk);
        addr = a; data = d; csn = 1'b0; wrn = 1'b0;
        repeat (3) @(negedge clk);
        csn = 1'b1; wrn = 1'b1;
        repeat (4) @(negedge clk);
        stg[a] = d;
    endtask

    task automatic commit();
        @(negedge clk);
        updn = 1'b0;
        repeat (3) @(negedge clk);
        updn = 1'b1;
        repeat (4) @(negedge clk);
        for (int i = 0; i < NO; i++) live[i] = stg[i];
    endtask

    task automatic t_reset();
        for (int i = 0; i < NO; i++) begin stg[i] = 4'b1000; live[i] = 4'b1000; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 en", int'(en), 0);
        chk("R1 sel", int'(sel), 0);
        chk("R1 asleep", int'(asleep), 0);
    endtask

    task automatic t_stage_only();
        stage_write(2'd1, 4'd5);
        check_all("R2");
    endtask

    task automatic t_commit_all();
        stage_write(2'd0, 4'd2);
        stage_write(2'd2, 4'd7);
        stage_write(2'd3, 4'd0);
        check_all("R2 staged");
        commit();
        check_all("R3 R4 R5");
    endtask

    task automatic t_disable();
        stage_write(2'd2, 4'b1101);
        check_all("R2 before off");
        commit();
        check_all("R6");
    endtask

    task automatic t_half_strobe();
        @(negedge clk);
        addr = 2'd0; data = 4'd6; csn = 1'b0; wrn = 1'b1;
        repeat (4) @(negedge clk);
        csn = 1'b1; wrn = 1'b0;
        repeat (4) @(negedge clk);
        wrn = 1'b1;
        repeat (3) @(negedge clk);
        commit();
        check_all("R7");
    endtask

    task automatic t_latency();
        @(negedge clk);
        addr = 2'd2; data = 4'd4; csn = 1'b0; wrn = 1'b0; updn = 1'b0;
        @(posedge clk);
        @(posedge clk);
        #2;
        chk("R10 en before", int'(en[2]), 0);
        @(posedge clk);
        #2;
        chk("R10 en after", int'(en[2]), 1);
        chk("R10 sel after", int'(sel[2*SW +: SW]), 4);
        @(negedge clk);
        csn = 1'b1; wrn = 1'b1; updn = 1'b1;
        repeat (4) @(negedge clk);
        stg[2] = 4'd4;
        for (int i = 0; i < NO; i++) live[i] = stg[i];
        check_all("R10 settle");
    endtask

    task automatic t_all_low();
        stage_write(2'd3, 4'd6);
        check_all("R2 pre");
        @(negedge clk);
        addr = 2'd1; data = 4'd3; csn = 1'b0; wrn = 1'b0; updn = 1'b0;
        repeat (3) @(negedge clk);
        csn = 1'b1; wrn = 1'b1; updn = 1'b1;
        repeat (4) @(negedge clk);
        stg[1] = 4'd3;
        for (int i = 0; i < NO; i++) live[i] = stg[i];
        check_all("R8");
    endtask

    task automatic t_sleep();
        @(negedge clk);
        sleep = 1'b1;
        repeat (4) @(negedge clk);
        sleeping = 1;
        check_all("R9 muted");
        stage_write(2'd0, 4'd1);
        stage_write(2'd3, 4'b1010);
        commit();
        check_all("R9 loaded");
        sleep = 1'b0;
        repeat (4) @(negedge clk);
        sleeping = 0;
        check_all("R9 woken");
    endtask

    initial begin
        t_reset();
        t_stage_only();
        t_commit_all();
        t_disable();
        t_half_strobe();
        t_latency();
        t_all_low();
        t_sleep();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule